// File: doc/BRIEF.md
# Branch Target Buffer Next-Fetch Predictor

This block sits in the fetch stage of a pipelined processor and chooses the next fetch address each cycle. It keeps a small direct-mapped table. Each entry records a branch seen earlier (as an index plus a tag taken from its fetch address) and the address that was fetched after that branch the last time it resolved. While an instruction is being fetched, its address is looked up. A valid entry with a matching tag supplies the stored address as the next program counter. Any other outcome falls back to the sequential address, the current PC plus one word.

Later pipeline stages write resolved branches through an update port. A taken branch stores its real target. A not-taken branch stores its own address plus one, so the entry stays resident and predicts fall-through the next time. The prediction is only "the same as last time": every resolution overwrites the stored address, and there is no confidence counter. When a stage reports a misprediction, the redirect address on the update port replaces the prediction in that same cycle. The wrongly fetched instruction then costs a single bubble.

Top module: `btb_fetch_pred`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears every valid bit. After reset every lookup misses (pred_hit = 0) until an update fills the entry.
- R2: On a miss with no redirect, next_pc = fetch_pc + 1, wrapping modulo 2^PC_W.
- R3: The index is fetch_pc[IDX_W-1:0] and the tag is the remaining upper bits. An update written at a clock edge makes a lookup of the same PC from the following cycle onward give pred_hit = 1 and next_pc = the stored target.
- R4: A lookup whose index matches a valid entry but whose tag differs is a miss.
- R5: An update with upd_taken = 0 stores upd_pc + 1 as the target and ignores upd_target. The entry stays valid.
- R6: A later update of the same branch replaces the stored target. The next lookup predicts the newest value.
- R7: When an update and a lookup fall on the same index in the same cycle, the lookup uses the update's tag and target in that cycle.
- R8: When upd_valid and upd_mispredict are both 1, next_pc = upd_redirect_pc in that same cycle, whatever the lookup gives. pred_hit still reports the lookup. The update is also written.
- R9: An update to an index held by a different tag evicts the older branch. That branch then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| next_pc | output | PC_W | Address to fetch next cycle |
| pred_hit | output | 1 | Lookup found a valid entry with matching tag |
| upd_valid | input | 1 | Resolved branch is presented on the update port |
| upd_pc | input | PC_W | Fetch address of the resolved branch |
| upd_taken | input | 1 | 1: the branch was taken; 0: fall-through |
| upd_target | input | PC_W | Taken target of the resolved branch |
| upd_mispredict | input | 1 | The earlier prediction was wrong; redirect fetch |
| upd_redirect_pc | input | PC_W | Corrected fetch address used on a misprediction |

## Verification
Lookups are purely combinational from the registered table. The bench drives inputs on the falling edge and checks pred_hit and next_pc one nanosecond later, in the same cycle. Updates and redirects are also due in the same cycle: the forwarding case (R7) and the redirect (R8) are checked before the rising edge that writes the table. A normal update becomes visible only in the following cycle. For that reason, the fill, replace and evict checks are taken at the falling edge after the writing rising edge, once the update inputs have been withdrawn.

// File: rtl/btb_fetch_pred.sv
module btb_fetch_pred #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] next_pc,
  output logic            pred_hit,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_mispredict,
  input  logic [PC_W-1:0] upd_redirect_pc
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  wire [IDX_W-1:0] f_idx = fetch_pc[IDX_W-1:0];
  wire [TAG_W-1:0] f_tag = fetch_pc[PC_W-1:IDX_W];
  wire [IDX_W-1:0] u_idx = upd_pc[IDX_W-1:0];
  wire [TAG_W-1:0] u_tag = upd_pc[PC_W-1:IDX_W];
  wire [PC_W-1:0]  u_tgt = upd_taken ? upd_target : upd_pc + PC_W'(1);

  wire             fwd    = upd_valid && (u_idx == f_idx);
  wire             rd_vld = fwd ? 1'b1 : valid_q[f_idx];
  wire [TAG_W-1:0] rd_tag = fwd ? u_tag : tag_q[f_idx];
  wire [PC_W-1:0]  rd_tgt = fwd ? u_tgt : tgt_q[f_idx];
  wire             redir  = upd_valid && upd_mispredict;

  assign pred_hit = rd_vld && (rd_tag == f_tag);
  assign next_pc  = redir    ? upd_redirect_pc :
                    pred_hit ? rd_tgt : fetch_pc + PC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         valid_q <= '0;
    else if (upd_valid) valid_q[u_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (upd_valid) begin
      tag_q[u_idx] <= u_tag;
      tgt_q[u_idx] <= u_tgt;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> valid_q == '0);

  assert_fill_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> valid_q[$past(u_idx)]);

  assert_hit_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_hit && !fwd) |-> (valid_q[f_idx] && tag_q[f_idx] == f_tag));

  assert_fallthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> tgt_q[$past(u_idx)] == $past(upd_pc) + PC_W'(1));

  assert_forward_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_pc == fetch_pc) |-> pred_hit);

  assert_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_mispredict) |-> next_pc == upd_redirect_pc);
endmodule

// File: tb/sim_btb_fetch_pred.sv
`timescale 1ns/1ps
module sim_btb_fetch_pred;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0, next_pc;
  logic        pred_hit;
  logic        upd_valid = 1'b0, upd_taken = 1'b0, upd_mispredict = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0, upd_redirect_pc = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  btb_fetch_pred u0 (.clk, .rst_n, .fetch_pc, .next_pc, .pred_hit,
    .upd_valid, .upd_pc, .upd_taken, .upd_target, .upd_mispredict, .upd_redirect_pc);

  task automatic chk(string req, logic exp_hit, logic [31:0] exp_pc);
    #1;
    checks++;
    if (pred_hit !== exp_hit || next_pc !== exp_pc) begin
      errors++;
      $display("FAIL %s pc=%h: hit=%0b next=%h expected hit=%0b next=%h",
               req, fetch_pc, pred_hit, next_pc, exp_hit, exp_pc);
    end
  endtask

  task automatic look(string req, logic [31:0] pc, logic exp_hit, logic [31:0] exp_pc);
    fetch_pc = pc;
    chk(req, exp_hit, exp_pc);
    @(negedge clk);
  endtask

  task automatic update(logic [31:0] pc, logic taken, logic [31:0] tgt);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = taken; upd_target = tgt;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look("R1", 32'h110, 1'b0, 32'h111);
    look("R1", 32'h100, 1'b0, 32'h101);
  endtask

  task automatic t_sequential;
    look("R2", 32'h2A, 1'b0, 32'h2B);
    look("R2", 32'hFFFF_FFFF, 1'b0, 32'h0);
  endtask

  task automatic t_taken;
    update(32'h100, 1'b1, 32'h40);
    look("R3", 32'h100, 1'b1, 32'h40);
    look("R4", 32'h110, 1'b0, 32'h111);
  endtask

  task automatic t_not_taken;
    update(32'h205, 1'b0, 32'h999);
    look("R5", 32'h205, 1'b1, 32'h206);
  endtask

  task automatic t_replace;
    update(32'h100, 1'b1, 32'h80);
    look("R6", 32'h100, 1'b1, 32'h80);
  endtask

  task automatic t_evict;
    update(32'h110, 1'b1, 32'h20);
    look("R9", 32'h100, 1'b0, 32'h101);
    look("R9", 32'h110, 1'b1, 32'h20);
  endtask

  task automatic t_forward;
    upd_valid = 1'b1; upd_pc = 32'h305; upd_taken = 1'b1; upd_target = 32'h500;
    fetch_pc = 32'h305;
    chk("R7", 1'b1, 32'h500);
    @(negedge clk);
    upd_valid = 1'b0;
    look("R7", 32'h205, 1'b0, 32'h206);
  endtask

  task automatic t_mispredict;
    upd_valid = 1'b1; upd_pc = 32'h40A; upd_taken = 1'b1; upd_target = 32'h777;
    upd_mispredict = 1'b1; upd_redirect_pc = 32'h777;
    fetch_pc = 32'h110;
    chk("R8", 1'b1, 32'h777);
    @(negedge clk);
    upd_valid = 1'b0; upd_mispredict = 1'b0;
    look("R8", 32'h110, 1'b1, 32'h20);
    look("R8", 32'h40A, 1'b1, 32'h777);
  endtask

  initial begin
    for (int i = 0; i < 5000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_sequential;
    t_taken;
    t_not_taken;
    t_replace;
    t_evict;
    t_forward;
    t_mispredict;
    t_reset;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule